// File: doc/BRIEF.md
# Reversal-Based Barrel Shifter

This block shifts a data word by a variable distance in one of three ways: logical left, logical right and arithmetic right. It has no clock and no registers. All three kinds share a single left-shifting datapath. That datapath is a cascade of fixed-distance stages, one for each bit of the shift amount. Each stage moves the word by a power of two when its amount bit is set, and it feeds a supplied fill bit into the low positions it vacates.

A right shift runs through the same stages. The operand is mirrored (bit i goes to bit WIDTH-1-i), shifted left, and mirrored back. The fill bit is zero for the logical kinds. For the arithmetic kind it is the operand's top bit, which makes the mirrored left shift behave as a sign-extending right shift.

The block sits in an execution unit beside the adder and logic functions. The surrounding logic drives the kind code and the amount and takes the result in the same cycle.

Top module: `revshift_unit`

## Requirements
- R1: With kind code 2'b00 the result is the operand shifted left by `sh_amt` places, with zeros in the vacated low bits.
- R2: With kind code 2'b10 the result is the operand shifted right by `sh_amt` places, with zeros in the vacated high bits.
- R3: With kind code 2'b11 the result is the operand shifted right by `sh_amt` places, with every vacated high bit equal to the operand's bit WIDTH-1.
- R4: When `sh_amt` is 0, the result equals the operand for every kind code.
- R5: Every amount from 0 to WIDTH-1 is honoured. At amount WIDTH-1 only one operand bit survives (left or logical right), or the whole word equals the sign bit (arithmetic right).
- R6: Kind code 2'b01 is not a separate shift kind. Bit 1 of the code selects the direction, and bit 0 matters only for right shifts, so 2'b01 gives exactly the logical-left result.
- R7: The result is a pure function of the present inputs. A change on any input shows up on `res` in the same time step, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sh_kind | input | 2 | Kind code: bit 1 selects right (1) or left (0); bit 0 selects arithmetic fill when shifting right |
| sh_amt | input | $clog2(WIDTH) | Shift distance, 0 to WIDTH-1 |
| opd | input | WIDTH | Data word to shift |
| res | output | WIDTH | Shifted word |

## Verification
The bench builds the block at its default width of 32, so the amount is 5 bits wide. At that width the whole amount range, 0 through 31, can be swept under all four kind codes with several operands. That sweep reaches each of the five stages, alone and in every combination, on both the mirrored and the direct path. Operands with the top bit set and with it clear separate arithmetic fill from zero fill. The extreme amounts 0 and 31 show whether the mirror stages and the stage cascade are wired end to end.

// File: rtl/rsh_pkg.sv
// Shared definitions for the reversal-based shifter.
// Assumes: the kind code is two bits wide; bit 1 means "right", bit 0 means "arithmetic".
package rsh_pkg;

    typedef enum logic [1:0] {
        SK_LSL  = 2'b00,
        SK_LSL2 = 2'b01,
        SK_LSR  = 2'b10,
        SK_ASR  = 2'b11
    } shkind_e;

    // True when the code asks for a right shift.
    function automatic logic kind_is_right(input logic [1:0] k);
        return k[1];
    endfunction

    // True when the code asks for a sign-extending right shift.
    function automatic logic kind_is_arith(input logic [1:0] k);
        return k[1] & k[0];
    endfunction

endpackage

// File: rtl/rsh_bitrev.sv
// Mirrors a word: input bit i appears at output bit W-1-i.
// Assumes: nothing beyond W >= 1; pure wiring.
module rsh_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_mirror
        // Route one bit to its mirrored position.
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/rsh_fill_sel.sv
// Picks the bit that enters vacated positions of the left-shift core.
// Assumes: zero fill for every logical kind, operand MSB for the arithmetic kind.
module rsh_fill_sel #(
    parameter int W = 32
) (
    input  logic [1:0]   kind,
    input  logic [W-1:0] opd,
    output logic         fill
);
    import rsh_pkg::*;

    logic msb;

    // Extract the operand's top bit.
    assign msb = opd[W-1];

    // Gate the top bit by the arithmetic-kind decode.
    always_comb begin
        fill = kind_is_arith(kind) ? msb : 1'b0;
    end

endmodule

// File: rtl/rsh_lstage_chain.sv
// Cascade of SW left-shift stages; stage i moves the word by 2**i places
// when amt[i] is set and inserts `fill` into each vacated low bit.
// Assumes: W is a power of two and SW = log2(W), so no stage distance reaches W.
module rsh_lstage_chain #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          fill,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stg [0:SW];

    assign stg[0] = din;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int DIST = 1 << i;
        logic [W-1:0] moved;

        // Form the shifted copy of the previous stage with fill bits below.
        assign moved = {stg[i][W-1-DIST:0], {DIST{fill}}};

        // Pass either the shifted or the untouched word to the next stage.
        always_comb begin
            stg[i+1] = amt[i] ? moved : stg[i];
        end
    end

    assign dout = stg[SW];

endmodule

// File: rtl/revshift_unit.sv
// Top of the shifter: one left-shift cascade serves left, logical right
// and arithmetic right shifts; right shifts are mirrored in and out.
// Assumes: WIDTH is a power of two; purely combinational, no clock or reset.
module revshift_unit #(
    parameter  int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [1:0]       sh_kind,
    input  logic [AMT_W-1:0] sh_amt,
    input  logic [WIDTH-1:0] opd,
    output logic [WIDTH-1:0] res
);
    import rsh_pkg::*;

    logic [WIDTH-1:0] opd_mir;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] out_mir;
    logic             fill_bit;
    logic             go_right;

    // Decode the direction once for both steering muxes.
    assign go_right = kind_is_right(sh_kind);

    rsh_bitrev #(.W(WIDTH)) u_mir_in (
        .din  (opd),
        .dout (opd_mir)
    );

    rsh_fill_sel #(.W(WIDTH)) u_fill (
        .kind (sh_kind),
        .opd  (opd),
        .fill (fill_bit)
    );

    // Steer the mirrored operand into the core for right shifts.
    always_comb begin
        core_in = go_right ? opd_mir : opd;
    end

    rsh_lstage_chain #(.W(WIDTH), .SW(AMT_W)) u_core (
        .din  (core_in),
        .amt  (sh_amt),
        .fill (fill_bit),
        .dout (core_out)
    );

    rsh_bitrev #(.W(WIDTH)) u_mir_out (
        .din  (core_out),
        .dout (out_mir)
    );

    // Undo the mirror on the way out for right shifts.
    always_comb begin
        res = go_right ? out_mir : core_out;
    end

endmodule

// File: rtl/rsh_check.sv
// Checker for revshift_unit: compares the output against native shift
// operators whenever the inputs are known. Attached by bind below.
// Assumes: combinational target, so immediate assertions are used.
module rsh_check #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input logic [1:0]    sh_kind,
    input logic [SW-1:0] sh_amt,
    input logic [W-1:0]  opd,
    input logic [W-1:0]  res
);

    logic known;
    assign known = !$isunknown({sh_kind, sh_amt, opd, res});

    // Check every shift kind and the corner amounts against native operators.
    always_comb begin
        if (known) begin
            if (sh_kind == 2'b00)
                assert_left_R1: assert (res == (opd << sh_amt));
            if (sh_kind == 2'b10)
                assert_lright_R2: assert (res == (opd >> sh_amt));
            if (sh_kind == 2'b11)
                assert_aright_R3: assert (res == W'($signed(opd) >>> sh_amt));
            if (sh_amt == '0)
                assert_zero_amt_R4: assert (res == opd);
            if (sh_kind == 2'b11 && sh_amt == SW'(W-1))
                assert_full_sign_R5: assert (res == {W{opd[W-1]}});
            if (sh_kind == 2'b10 && sh_amt == SW'(W-1))
                assert_full_lsr_R5: assert ($countones(res) == int'(opd[W-1]));
            if (sh_kind == 2'b01)
                assert_code01_R6: assert (res == (opd << sh_amt));
        end
    end

endmodule

bind revshift_unit rsh_check #(.W(WIDTH), .SW(AMT_W)) u_chk (
    .sh_kind (sh_kind),
    .sh_amt  (sh_amt),
    .opd     (opd),
    .res     (res)
);

// File: tb/sim_revshift_unit.sv
// Self-checking bench for revshift_unit at WIDTH = 32.
module sim_revshift_unit;

    localparam int W  = 32;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic [1:0]    sh_kind;
    logic [SW-1:0] sh_amt;
    logic [W-1:0]  opd;
    logic [W-1:0]  res;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    revshift_unit #(.WIDTH(W)) u0 (
        .sh_kind (sh_kind),
        .sh_amt  (sh_amt),
        .opd     (opd),
        .res     (res)
    );

    typedef struct packed {
        logic [1:0]    k;
        logic [SW-1:0] a;
        logic [W-1:0]  d;
        logic [W-1:0]  e;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [0:NV-1] = '{
        '{2'b00, 5'd4,  32'h0000_00FF, 32'h0000_0FF0},  // R1
        '{2'b00, 5'd16, 32'h0000_ABCD, 32'hABCD_0000},  // R1
        '{2'b00, 5'd31, 32'h0000_0003, 32'h8000_0000},  // R5
        '{2'b10, 5'd8,  32'h1234_5678, 32'h0012_3456},  // R2
        '{2'b10, 5'd31, 32'h8000_0000, 32'h0000_0001},  // R5
        '{2'b10, 5'd4,  32'hF000_0000, 32'h0F00_0000},  // R2
        '{2'b11, 5'd4,  32'hF000_0000, 32'hFF00_0000},  // R3
        '{2'b11, 5'd16, 32'h7FFF_0000, 32'h0000_7FFF},  // R3
        '{2'b11, 5'd31, 32'h8000_0000, 32'hFFFF_FFFF},  // R5
        '{2'b00, 5'd0,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R4
        '{2'b10, 5'd0,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R4
        '{2'b11, 5'd0,  32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R4
        '{2'b01, 5'd1,  32'h0000_0001, 32'h0000_0002}   // R6
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: kind=%b amt=%0d opd=%h got=%h expected=%h",
                     tag, sh_kind, sh_amt, opd, got, exp);
        end
    endtask

    task automatic apply(input logic [1:0] k, input logic [SW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        sh_kind = k;
        sh_amt  = a;
        opd     = d;
        #1;
    endtask

    function automatic logic [W-1:0] ref_shift(input logic [1:0] k, input logic [SW-1:0] a,
                                               input logic [W-1:0] d);
        if (!k[1])     return d << a;
        else if (!k[0]) return d >> a;
        else            return W'($signed(d) >>> a);
    endfunction

    function automatic string tag_of(input logic [1:0] k);
        case (k)
            2'b00:   return "R1";
            2'b01:   return "R6";
            2'b10:   return "R2";
            default: return "R3";
        endcase
    endfunction

    initial begin
        logic [W-1:0] ops [0:3];
        ops[0] = 32'h8000_0001;
        ops[1] = 32'h7FFF_FFFE;
        ops[2] = 32'hA5C3_3C5A;
        ops[3] = 32'hFFFF_FFFF;

        // Idle state: zero amount returns the operand (R4).
        apply(2'b00, '0, 32'h0000_0000);
        check("R4", res, 32'h0000_0000);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            apply(TBL[i].k, TBL[i].a, TBL[i].d);
            check(TBL[i].a == 0 ? "R4" : (TBL[i].a == 31 ? "R5" : tag_of(TBL[i].k)), res, TBL[i].e);
        end

        // Sweep every amount under every kind (R1, R2, R3, R5, R6).
        for (int o = 0; o < 4; o++) begin
            for (int k = 0; k < 4; k++) begin
                for (int a = 0; a < W; a++) begin
                    apply(k[1:0], a[SW-1:0], ops[o]);
                    check(tag_of(k[1:0]), res, ref_shift(k[1:0], a[SW-1:0], ops[o]));
                end
            end
        end

        // R7: output follows an input change within the same time step.
        @(negedge clk);
        sh_kind = 2'b10; sh_amt = 5'd1; opd = 32'h0000_0100;
        #0.5;
        check("R7", res, 32'h0000_0080);
        opd = 32'h0000_0200;
        #0.5;
        check("R7", res, 32'h0000_0100);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule